// File: doc/BRIEF.md
# Carry-Save Array Multiplier

This block multiplies two unsigned operands of equal width and returns the full double-width product. A grid of AND gates forms every partial-product bit in the same instant. Rows of adder cells then reduce the partial products without rippling a carry along any row: each cell hands its sum straight down to the row below and its carry down and one column to the left. Because of this, a row costs one full-adder delay whatever its width. One low-order product bit drops out of the grid at the end of each row. A single carry-lookahead merge adder then resolves the last sum and carry vectors into the upper half of the product.

Cells in the first adder row, and cells in the leftmost column, have only two live inputs, so they are built as half adders. The operand width and the lookahead group size of the merge adder are parameters. A parameter also selects whether the product is held in an output register, which adds one cycle of latency, or leaves the block as pure combinational logic.

Top module: `csa_mul_array`

## Requirements
- R1: `product` equals the unsigned product of `a` and `b`, in 2·WIDTH bits, for every pair of operand values.
- R2: With REG_OUT=1 the product of the operands present at a rising clock edge appears on `product` after that edge and holds until the next edge. While `rst_n` is low, `product` is 0.
- R3: With REG_OUT=0, `product` follows the operands combinationally in the same cycle, with no clock edge needed.
- R4: If either operand is zero, `product` is zero.
- R5: If `b` is 1, `product` equals `a` zero-extended to 2·WIDTH bits.
- R6: All-ones times all-ones gives 2^(2·WIDTH) − 2^(WIDTH+1) + 1. The carry out of the merge adder is never set, so the result never exceeds 2·WIDTH bits.
- R7: If `b` is 2^k, `product` equals `a` shifted left by k bit positions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register and for the checks |
| rst_n | input | 1 | Asynchronous reset, active low; clears the output register |
| a | input | WIDTH | Multiplicand, unsigned |
| b | input | WIDTH | Multiplier, unsigned |
| product | output | 2·WIDTH | Unsigned product of `a` and `b` |

## Verification
The properties sample `a`, `b` and `product` at the rising clock edge. They therefore assume the operands are known values that settle well before that edge. In the registered variant they also assume the operands stay constant from one edge until the result is compared at the next. The bench changes the operands only on the falling edge and holds them for a whole cycle. This keeps both the registered and the combinational instance inside that assumption. The bench covers every operand pair of the 4-bit instance exhaustively. It then mixes seeded random pairs for the 8-bit instance with zero, one, all-ones and power-of-two operands.

// File: rtl/csa_mul_pkg.sv
package csa_mul_pkg;
   // Result of one reduction cell: sum goes down, carry goes down-left
   typedef struct packed {
      logic cy;
      logic sm;
   } csa_bit_t;
endpackage

// File: rtl/csa_pp_ha.sv
module csa_pp_ha
   import csa_mul_pkg::*;
(
   input  logic     ai,
   input  logic     bj,
   input  logic     din,
   output csa_bit_t res
);
   logic pp;
   assign pp     = ai & bj;
   assign res.sm = pp ^ din;
   assign res.cy = pp & din;
endmodule

// File: rtl/csa_pp_fa.sv
module csa_pp_fa
   import csa_mul_pkg::*;
(
   input  logic     ai,
   input  logic     bj,
   input  logic     sin,
   input  logic     cin,
   output csa_bit_t res
);
   logic pp;
   assign pp     = ai & bj;
   assign res.sm = pp ^ sin ^ cin;
   assign res.cy = (pp & sin) | (pp & cin) | (sin & cin);
endmodule

// File: rtl/csa_pp_array.sv
module csa_pp_array
   import csa_mul_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   output logic [WIDTH-1:0] lo_bits,
   output logic [WIDTH-1:0] merge_x,
   output logic [WIDTH-1:0] merge_y
);
   localparam int LAST = WIDTH - 1;

   // rs[j][i] has weight 2^(i+j); rc[j][i] has weight 2^(i+j+1)
   logic [LAST:0][WIDTH-1:0] rs;
   logic [LAST:1][WIDTH-1:0] rc;

   for (genvar j = 0; j < WIDTH; j++) begin : g_row
      for (genvar i = 0; i < WIDTH; i++) begin : g_col
         if (j == 0) begin : g_and
            assign rs[0][i] = a[i] & b[0];
         end else begin : g_add
            csa_bit_t r;
            if (j == 1) begin : g_ha_top
               logic above;
               if (i < LAST) begin : g_in
                  assign above = rs[0][i+1];
               end else begin : g_edge
                  assign above = 1'b0;
               end
               csa_pp_ha u_cell (.ai(a[i]), .bj(b[j]), .din(above), .res(r));
            end else if (i == LAST) begin : g_ha_left
               csa_pp_ha u_cell (.ai(a[i]), .bj(b[j]), .din(rc[j-1][i]), .res(r));
            end else begin : g_fa
               csa_pp_fa u_cell (.ai(a[i]), .bj(b[j]), .sin(rs[j-1][i+1]),
                                 .cin(rc[j-1][i]), .res(r));
            end
            assign rs[j][i] = r.sm;
            assign rc[j][i] = r.cy;
         end
      end
      assign lo_bits[j] = rs[j][0];
   end

   assign merge_x = {1'b0, rs[LAST][LAST:1]};
   assign merge_y = rc[LAST];
endmodule

// File: rtl/csa_cla_merge.sv
module csa_cla_merge #(
   parameter int WIDTH = 8,
   parameter int GRP   = 4
) (
   input  logic [WIDTH-1:0] x,
   input  logic [WIDTH-1:0] y,
   output logic [WIDTH-1:0] sum,
   output logic             cout
);
   localparam int NGRP = (WIDTH + GRP - 1) / GRP;
   localparam int PW   = NGRP * GRP;

   logic [PW-1:0] xp, yp, g, p;
   logic [PW:0]   cv;
   logic          gin, term, prodv;

   assign xp = PW'(x);
   assign yp = PW'(y);
   assign g  = xp & yp;
   assign p  = xp ^ yp;

   // Each carry is a flat sum of products of g/p terms within its group
   always_comb begin
      cv    = '0;
      gin   = 1'b0;
      term  = 1'b0;
      prodv = 1'b0;
      for (int k = 0; k < NGRP; k++) begin
         for (int t = 0; t < GRP; t++) begin
            term = gin;
            for (int q = 0; q <= t; q++) term = term & p[k*GRP+q];
            for (int m = 0; m <= t; m++) begin
               prodv = g[k*GRP+m];
               for (int q = m + 1; q <= t; q++) prodv = prodv & p[k*GRP+q];
               term = term | prodv;
            end
            cv[k*GRP+t+1] = term;
         end
         gin = cv[(k+1)*GRP];
      end
   end

   assign sum  = p[WIDTH-1:0] ^ cv[WIDTH-1:0];
   assign cout = cv[WIDTH];
endmodule

// File: rtl/csa_mul_array.sv
module csa_mul_array #(
   parameter int WIDTH     = 8,
   parameter int MERGE_GRP = 4,
   parameter bit REG_OUT   = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [WIDTH-1:0]   a,
   input  logic [WIDTH-1:0]   b,
   output logic [2*WIDTH-1:0] product
);
   localparam int PW = 2 * WIDTH;

   if (WIDTH < 2) begin : g_bad_width
      $error("csa_mul_array: WIDTH must be at least 2");
   end
   if (MERGE_GRP < 1) begin : g_bad_grp
      $error("csa_mul_array: MERGE_GRP must be at least 1");
   end

   logic [WIDTH-1:0] lo_bits, merge_x, merge_y, hi_bits;
   logic             merge_cout;
   logic [PW-1:0]    prod_c;

   csa_pp_array #(.WIDTH(WIDTH)) u_array (
      .a       (a),
      .b       (b),
      .lo_bits (lo_bits),
      .merge_x (merge_x),
      .merge_y (merge_y)
   );

   csa_cla_merge #(.WIDTH(WIDTH), .GRP(MERGE_GRP)) u_merge (
      .x    (merge_x),
      .y    (merge_y),
      .sum  (hi_bits),
      .cout (merge_cout)
   );

   assign prod_c = {hi_bits, lo_bits};

   if (REG_OUT) begin : g_reg
      logic [PW-1:0] prod_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prod_q <= '0;
         else        prod_q <= prod_c;
      end
      assign product = prod_q;
   end else begin : g_comb
      assign product = prod_c;
   end
endmodule

// File: rtl/csa_mul_chk.sv
module csa_mul_chk #(
   parameter int WIDTH   = 8,
   parameter bit REG_OUT = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic [WIDTH-1:0]   a,
   input logic [WIDTH-1:0]   b,
   input logic [2*WIDTH-1:0] product,
   input logic               merge_cout
);
   localparam int PW = 2 * WIDTH;
   localparam logic [PW-1:0] MAXP = {PW{1'b1}} - (PW'(1) << (WIDTH + 1)) + PW'(2);

   logic [PW-1:0] ax, bx;
   assign ax = PW'(a);
   assign bx = PW'(b);

   // R6
   merge_no_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !merge_cout);

   if (REG_OUT) begin : g_reg
      // R1
      product_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
         rst_n |=> product == $past(ax) * $past(bx));
      // R4
      zero_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (a == '0 || b == '0) |=> product == '0);
      // R5
      unit_multiplier_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (b == WIDTH'(1)) |=> product == $past(ax));
      // R6
      all_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (&a && &b) |=> product == MAXP);
   end else begin : g_comb
      // R3
      product_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
         product == ax * bx);
      // R4
      zero_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (a == '0 || b == '0) |-> product == '0);
      // R5
      unit_multiplier_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (b == WIDTH'(1)) |-> product == ax);
      // R6
      all_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (&a && &b) |-> product == MAXP);
   end
endmodule

bind csa_mul_array csa_mul_chk #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .a          (a),
   .b          (b),
   .product    (product),
   .merge_cout (merge_cout)
);

// File: tb/csa_mul_array_bench.sv
module csa_mul_array_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  a8 = '0, b8 = '0;
   logic [15:0] product8;
   logic [3:0]  a4 = '0, b4 = '0;
   logic [7:0]  product4;
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   csa_mul_array #(.WIDTH(8), .MERGE_GRP(4), .REG_OUT(1'b1)) u_csa_mul_array (
      .clk(clk), .rst_n(rst_n), .a(a8), .b(b8), .product(product8));

   csa_mul_array #(.WIDTH(4), .MERGE_GRP(3), .REG_OUT(1'b0)) u_csa_mul_array_w4 (
      .clk(clk), .rst_n(rst_n), .a(a4), .b(b4), .product(product4));

   function automatic logic [31:0] ref_mul(logic [15:0] x, logic [15:0] y);
      logic [31:0] acc = '0;
      for (int k = 0; k < 16; k++)
         if (y[k]) acc = acc + (32'(x) << k);
      return acc;
   endfunction

   task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %h expected %h", tag, got, exp);
      end
   endtask

   // Registered 8-bit instance: drive on falling edge, result after next rising edge
   task automatic mul8(string tag, logic [7:0] x, logic [7:0] y);
      logic [15:0] prev;
      @(negedge clk);
      prev = product8;
      a8 = x; b8 = y;
      #1 check("R2 hold", 32'(product8), 32'(prev));
      @(negedge clk);
      check(tag, 32'(product8), ref_mul(16'(x), 16'(y)));
   endtask

   // Combinational 4-bit instance
   task automatic mul4(string tag, logic [3:0] x, logic [3:0] y);
      @(negedge clk);
      a4 = x; b4 = y;
      #1 check(tag, 32'(product4), ref_mul(16'(x), 16'(y)));
   endtask

   initial begin
      #(4 * 200000);
      errors++;
      $display("FAIL watchdog expired");
      if (!done) begin
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      a8 = 8'hff; b8 = 8'hff;
      repeat (3) @(negedge clk);
      check("R2 reset", 32'(product8), 32'h0);
      rst_n = 1'b1;

      // R4 zero operands
      mul8("R4 a zero", 8'h00, 8'hb7);
      mul8("R4 b zero", 8'h5c, 8'h00);
      mul4("R4 w4 zero", 4'h0, 4'hf);
      // R5 unit multiplier
      mul8("R5 b one", 8'hd3, 8'h01);
      mul4("R5 w4 b one", 4'hb, 4'h1);
      // R6 all ones
      mul8("R6 all ones", 8'hff, 8'hff);
      check("R6 value", 32'(product8), 32'hfe01);
      mul4("R6 w4 all ones", 4'hf, 4'hf);
      // R7 powers of two
      for (int k = 0; k < 8; k++) mul8("R7 pow2", 8'ha9, 8'(1 << k));
      for (int k = 0; k < 4; k++) mul4("R7 w4 pow2", 4'h7, 4'(1 << k));

      // R3 R1 exhaustive 4-bit combinational
      for (int x = 0; x < 16; x++)
         for (int y = 0; y < 16; y++)
            mul4("R3 R1 w4 exhaustive", 4'(x), 4'(y));

      // R1 random 8-bit registered, biased toward dense operands
      for (int n = 0; n < 1500; n++) begin
         logic [7:0] x, y;
         x = 8'($urandom);
         y = 8'($urandom);
         if (n % 7 == 0) x = x | 8'hf0;
         if (n % 11 == 0) y = y | 8'h0f;
         mul8("R1 random", x, y);
      end

      // R2 back-to-back operands each see their own result
      mul8("R2 seq a", 8'h80, 8'h80);
      mul8("R2 seq b", 8'h7f, 8'h81);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule